// File: doc/BRIEF.md
# Floppy GCR Write Serializer

This block turns a stream of bytes into the flux pulse train that a floppy write head needs. Each byte is shifted out MSB first, one bit per cell of two half-cells. A bit of 1 gives a single one-clock pulse in the middle of its cell, and a bit of 0 gives no pulse. The half-cell length is a runtime input in clocks, so one instance serves several data rates. The host writes bytes through a valid/ready port and switches the write path on and off with a level input.

There are two pacing modes. In synchronous mode the host feeds the shift register directly: the byte in the data register is loaded when writing starts, and any later host write during the write replaces the shift register at once. When the bits run out, zeros shift out. In asynchronous mode a handshake register decouples the host from the cell timing. Bit 7 means the holding byte has been consumed and bit 6 means a write is in progress. Seven clocks into every eight-cell byte frame, the block fetches the holding byte. If the host has not refilled it by then, the block aborts with a sticky underrun flag.

Back-pressure rules: `in_ready` is always high, so every beat with `in_valid` high is taken on that clock edge into the data register. A later beat overwrites an earlier one that has not been fetched. In asynchronous mode the host paces itself by polling handshake bit 7.

Top module: `gcr_wr_serializer`

## Requirements
- R1: After reset the handshake register reads 0xBF, `flux_pulse` and `underrun` are low, and `in_ready` is high.
- R2: Writing starts on the first edge where `write_on` is seen high after being low, and that edge sets handshake bit 6. The edge where `write_on` is first seen low clears bit 6, returns the block to idle and stops all further pulses.
- R3: An accepted beat with `async_mode` high clears handshake bit 7. With `async_mode` low, bit 7 is left unchanged.
- R4: In asynchronous mode, the byte fetch happens on the 7th edge after the start edge and then every 16·H edges, where H is the half-cell length. If bit 7 is still set at a fetch, the block raises `underrun`, clears bit 6, goes idle and emits no further pulses.
- R5: A successful fetch copies the data register into the shift register and sets handshake bit 7.
- R6: Counting stream bits n = 0,1,… from the MSB of the first byte, a 1-bit gives `flux_pulse` high for exactly one clock, in the cycle after edge S + H·(2n+1), where S is the start edge. A 0-bit gives no pulse, and no pulse appears at any other time.
- R7: In asynchronous mode, consecutive bytes form one unbroken cell train: after 8 bits the next byte's first bit falls in the very next cell.
- R8: In synchronous mode, the data register is loaded into the shift register at the start edge. A beat accepted while writing replaces the shift register on that edge, and cells with no new byte shift out zeros.
- R9: `underrun` stays high, even after writing stops, until the next start edge clears it.
- R10: The half-cell length `half_cell` is a runtime input, valid from 8 up to 2^HALF_W−1 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Host byte beat valid |
| in_ready | output | 1 | Always high; every beat is accepted |
| in_data | input | 8 | Host byte |
| write_on | input | 1 | Level: write path enabled |
| async_mode | input | 1 | 1 = handshake pacing, 0 = direct shift loading |
| half_cell | input | HALF_W | Half-cell length in clocks (8 or more) |
| flux_pulse | output | 1 | One-clock pulse per 1-bit |
| hs_reg | output | 8 | Handshake: bit 7 holding empty, bit 6 writing, bits 5:0 read 1 |
| underrun | output | 1 | Sticky underrun flag |

## Verification
The bench sweeps several half-cell lengths, including the minimum of 8. At that minimum the post-fetch delay is one clock, and a timer that treated a reload of 1 as idle would drop the first bit. Every cycle of each run is compared with the pulse schedule computed from the bit stream. This catches a fetch placed off by one cycle, a lost cell at a byte boundary, or a pulse held for two clocks. The underrun test also checks the cycle before the fetch, which exposes a fetch that comes early or late. Further tests cover the sticky flag surviving a stop and being cleared only on restart, a synchronous host write that wrongly touches bit 7, and pulses that go on after `write_on` drops.

// File: rtl/gcr_wr_pkg.sv
package gcr_wr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_MID  = 2'd2,
    ST_END  = 2'd3
  } wr_state_e;

  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FETCH_LAG   = 7;
  localparam int unsigned HS_W        = 8;
  localparam logic [7:0]  HS_RESET    = 8'hBF;
  localparam int unsigned HS_EMPTY    = 7;
  localparam int unsigned HS_ACTIVE   = 6;
  localparam int unsigned MIN_HALF    = FETCH_LAG + 1;

endpackage

// File: rtl/gcr_cell_timer.sv
module gcr_cell_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic [W-1:0] arm_val,
  input  logic         halt,
  output logic         due
);

  logic [W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (halt) begin
      count_q <= '0;
    end else if (arm) begin
      count_q <= arm_val;
    end else if (count_q != '0) begin
      count_q <= count_q - W'(1);
    end
  end

  assign due = (count_q == W'(1));

  // a halted timer never fires on the following cycle
  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> !due); // R2

endmodule

// File: rtl/gcr_handshake.sv
module gcr_handshake
  import gcr_wr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic            async_mode,
  input  logic            set_active,
  input  logic            clr_active,
  input  logic            refill,
  output logic [HS_W-1:0] hs
);

  logic [HS_W-1:0] hs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q <= HS_RESET;
    end else begin
      if (host_wr && async_mode) begin
        hs_q[HS_EMPTY] <= 1'b0;
      end else if (refill) begin
        hs_q[HS_EMPTY] <= 1'b1;
      end
      if (clr_active) begin
        hs_q[HS_ACTIVE] <= 1'b0;
      end else if (set_active) begin
        hs_q[HS_ACTIVE] <= 1'b1;
      end
    end
  end

  assign hs = hs_q;

  AST_HOST_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && async_mode) |=> !hs[HS_EMPTY]); // R3

  AST_SYNC_KEEPS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !async_mode && !refill) |=> $stable(hs[HS_EMPTY])); // R3

  AST_REFILL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (refill && !host_wr) |=> hs[HS_EMPTY]); // R5

endmodule

// File: rtl/gcr_shifter.sv
module gcr_shifter #(
  parameter int unsigned BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BITS-1:0] load_byte,
  input  logic            shift,
  input  logic            cnt_init,
  input  logic            cnt_step,
  output logic            msb,
  output logic            cnt_last
);

  localparam int unsigned CW = $clog2(BITS + 1);

  logic [BITS-1:0] sreg_q;
  logic [CW-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load) begin
      sreg_q <= load_byte;
    end else if (shift) begin
      sreg_q <= {sreg_q[BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_init) begin
      cnt_q <= CW'(BITS);
    end else if (cnt_step && cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign msb      = sreg_q[BITS-1];
  assign cnt_last = (cnt_q == CW'(1));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(BITS)); // R7

  AST_SHIFT_FILLS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !load) |=> !sreg_q[0]); // R8

endmodule

// File: rtl/gcr_wr_serializer.sv
module gcr_wr_serializer
  import gcr_wr_pkg::*;
#(
  parameter int unsigned HALF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              write_on,
  input  logic              async_mode,
  input  logic [HALF_W-1:0] half_cell,
  output logic              flux_pulse,
  output logic [HS_W-1:0]   hs_reg,
  output logic              underrun
);

  localparam logic [HALF_W-1:0] LAG_V = HALF_W'(FETCH_LAG);

  wr_state_e         state_q, state_d;
  logic              on_q;
  logic [BYTE_W-1:0] data_q;
  logic              pulse_q, pulse_d;
  logic              urun_q;

  logic              enter, leave;
  logic              due;
  logic              arm, halt;
  logic [HALF_W-1:0] arm_val;
  logic              sh_load, sh_shift, cnt_init, cnt_step;
  logic [BYTE_W-1:0] sh_data;
  logic              msb, cnt_last;
  logic              refill, set_act, clr_act, urun_set;
  logic [HS_W-1:0]   hs;

  assign in_ready = 1'b1;
  assign enter    = write_on && !on_q;
  assign leave    = !write_on && on_q;

  gcr_cell_timer #(.W(HALF_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .arm_val (arm_val),
    .halt    (halt),
    .due     (due)
  );

  gcr_shifter #(.BITS(BYTE_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sh_load),
    .load_byte (sh_data),
    .shift     (sh_shift),
    .cnt_init  (cnt_init),
    .cnt_step  (cnt_step),
    .msb       (msb),
    .cnt_last  (cnt_last)
  );

  gcr_handshake u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (in_valid),
    .async_mode (async_mode),
    .set_active (set_act),
    .clr_active (clr_act),
    .refill     (refill),
    .hs         (hs)
  );

  always_comb begin
    state_d  = state_q;
    arm      = 1'b0;
    arm_val  = half_cell;
    halt     = 1'b0;
    sh_load  = 1'b0;
    sh_data  = data_q;
    sh_shift = 1'b0;
    cnt_init = 1'b0;
    cnt_step = 1'b0;
    refill   = 1'b0;
    set_act  = 1'b0;
    clr_act  = 1'b0;
    urun_set = 1'b0;
    pulse_d  = 1'b0;

    if (leave) begin
      state_d = ST_IDLE;
      halt    = 1'b1;
      clr_act = 1'b1;
    end else if (enter) begin
      set_act = 1'b1;
      arm     = 1'b1;
      if (async_mode) begin
        state_d  = ST_LOAD;
        arm_val  = LAG_V;
        cnt_init = 1'b1;
      end else begin
        state_d = ST_MID;
        sh_load = 1'b1;
      end
    end else begin
      unique case (state_q)
        ST_LOAD: begin
          if (due) begin
            if (hs[HS_EMPTY]) begin
              state_d  = ST_IDLE;
              halt     = 1'b1;
              clr_act  = 1'b1;
              urun_set = 1'b1;
            end else begin
              state_d = ST_MID;
              sh_load = 1'b1;
              refill  = 1'b1;
              arm     = 1'b1;
              arm_val = half_cell - LAG_V;
            end
          end
        end
        ST_MID: begin
          if (due) begin
            pulse_d  = msb;
            sh_shift = 1'b1;
            state_d  = ST_END;
            arm      = 1'b1;
          end
        end
        ST_END: begin
          if (due) begin
            arm = 1'b1;
            if (async_mode) begin
              cnt_step = 1'b1;
              if (cnt_last) begin
                state_d  = ST_LOAD;
                arm_val  = LAG_V;
                cnt_init = 1'b1;
              end else begin
                state_d = ST_MID;
              end
            end else begin
              state_d = ST_MID;
            end
          end
        end
        default: begin
          state_d = ST_IDLE;
        end
      endcase

      // synchronous pacing: a host byte goes straight into the shifter
      if (!async_mode && in_valid &&
          (state_q == ST_MID || state_q == ST_END)) begin
        sh_load  = 1'b1;
        sh_data  = in_data;
        sh_shift = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      on_q    <= 1'b0;
      data_q  <= '0;
      pulse_q <= 1'b0;
      urun_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      on_q    <= write_on;
      pulse_q <= pulse_d;
      if (in_valid) begin
        data_q <= in_data;
      end
      if (enter) begin
        urun_q <= 1'b0;
      end else if (urun_set) begin
        urun_q <= 1'b1;
      end
    end
  end

  assign flux_pulse = pulse_q;
  assign hs_reg     = hs;
  assign underrun   = urun_q;

  AST_ENTER_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> hs_reg[HS_ACTIVE]); // R2

  AST_LEAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    leave |=> (!hs_reg[HS_ACTIVE] && state_q == ST_IDLE)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> !flux_pulse); // R2

  AST_UNDERRUN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(underrun) |-> (state_q == ST_IDLE && !hs_reg[HS_ACTIVE])); // R4

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    flux_pulse |=> !flux_pulse); // R6

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !enter) |=> underrun); // R9

  AST_ENTER_CLEARS_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> !underrun); // R9

  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    write_on |-> (half_cell >= HALF_W'(MIN_HALF))); // R10

endmodule

// File: tb/sim_gcr_wr_serializer.sv
module sim_gcr_wr_serializer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic       write_on = 1'b0;
  logic       async_mode = 1'b0;
  logic [7:0] half_cell = 8'd14;
  logic       flux_pulse;
  logic [7:0] hs_reg;
  logic       underrun;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [7:0] stream [0:3];

  always #10 clk = ~clk;

  gcr_wr_serializer #(.HALF_W(8)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .write_on   (write_on),
    .async_mode (async_mode),
    .half_cell  (half_cell),
    .flux_pulse (flux_pulse),
    .hs_reg     (hs_reg),
    .underrun   (underrun)
  );

  task automatic tick;
    @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // pulse expected in the cycle after edge S+t: t = h*(2n+1), bit n is 1
  function automatic int exp_pulse(input int t, input int h, input int nbits);
    int n;
    if (t < h) return 0;
    if (((t - h) % (2 * h)) != 0) return 0;
    n = (t - h) / (2 * h);
    if (n >= nbits) return 0;
    return int'(stream[n / 8][7 - (n % 8)]);
  endfunction

  task automatic run_async(input int h, input int nb);
    int last;
    half_cell  = 8'(h);
    async_mode = 1'b1;
    tick;
    in_valid = 1'b1;
    in_data  = stream[0];
    tick;
    in_valid = 1'b0;
    check("R3 async write empties", int'(hs_reg[7]), 0);
    write_on = 1'b1;
    last = 16 * h * nb + 7;
    for (int t = 0; t <= last + 4; t++) begin
      tick;
      in_valid = 1'b0;
      check("R6/R7 async pulse", int'(flux_pulse), exp_pulse(t, h, 8 * nb));
      if (t == 0) check("R2 active after start", int'(hs_reg[6]), 1);
      for (int j = 0; j < nb; j++) begin
        if (t == 7 + 16 * h * j) check("R5 fetch sets empty", int'(hs_reg[7]), 1);
        if (j + 1 < nb && t == 7 + 16 * h * j + 3) begin
          in_valid = 1'b1;
          in_data  = stream[j + 1];
        end
        if (j + 1 < nb && t == 7 + 16 * h * j + 5)
          check("R3 refill clears empty", int'(hs_reg[7]), 0);
      end
      if (t == last - 1) check("R4 no underrun before fetch", int'(underrun), 0);
      if (t == last) begin
        check("R4 underrun at fetch", int'(underrun), 1);
        check("R4 abort clears active", int'(hs_reg[6]), 0);
      end
    end
    write_on = 1'b0;
    tick;
    tick;
    check("R9 underrun sticky after stop", int'(underrun), 1);
  endtask

  task automatic run_sync(input int h, input int nb);
    half_cell  = 8'(h);
    async_mode = 1'b0;
    tick;
    in_valid = 1'b1;
    in_data  = stream[0];
    tick;
    in_valid = 1'b0;
    check("R3 sync write keeps empty", int'(hs_reg[7]), 1);
    write_on = 1'b1;
    for (int t = 0; t < 16 * h * nb + 4 * h; t++) begin
      tick;
      in_valid = 1'b0;
      check("R8 sync pulse", int'(flux_pulse), exp_pulse(t, h, 8 * nb));
      if (t == 0) check("R2 handshake while writing", int'(hs_reg), 'hFF);
      for (int j = 1; j < nb; j++) begin
        if (t == 16 * h * j) begin
          in_valid = 1'b1;
          in_data  = stream[j];
        end
        if (t == 16 * h * j + 2) check("R3 sync write keeps empty", int'(hs_reg[7]), 1);
      end
    end
    write_on = 1'b0;
    tick;
    check("R2 stop clears active", int'(hs_reg[6]), 0);
    for (int t = 0; t < 3 * h; t++) begin
      tick;
      check("R2 quiet after stop", int'(flux_pulse), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) tick;
    rst_n = 1'b1;
    tick;
    check("R1 reset handshake", int'(hs_reg), 'hBF);
    check("R1 reset pulse", int'(flux_pulse), 0);
    check("R1 reset underrun", int'(underrun), 0);
    check("R1 ready", int'(in_ready), 1);

    // synchronous mode, two half-cell lengths
    stream[0] = 8'hD5; stream[1] = 8'hAA; stream[2] = 8'h96; stream[3] = 8'h00;
    run_sync(8, 2);
    stream[0] = 8'h81; stream[1] = 8'hFF; stream[2] = 8'h3C;
    run_sync(13, 3);

    // asynchronous mode sweep of half-cell lengths (R10)
    stream[0] = 8'hFF; stream[1] = 8'h81; stream[2] = 8'hA5;
    run_async(8, 3);
    stream[0] = 8'hD5; stream[1] = 8'hAA; stream[2] = 8'h01;
    run_async(11, 3);
    stream[0] = 8'h96; stream[1] = 8'hEB; stream[2] = 8'h00;
    run_async(14, 3);

    // start with no byte supplied: immediate underrun at the first fetch
    half_cell  = 8'd10;
    async_mode = 1'b1;
    tick;
    write_on = 1'b1;
    for (int t = 0; t < 14; t++) begin
      tick;
      check("R6 no pulse on underrun", int'(flux_pulse), 0);
      if (t == 0) check("R9 restart clears underrun", int'(underrun), 0);
      if (t == 6) check("R4 fetch not early", int'(underrun), 0);
      if (t == 7) check("R4 immediate underrun", int'(underrun), 1);
      if (t == 7) check("R4 active cleared", int'(hs_reg[6]), 0);
    end
    write_on = 1'b0;
    tick;
    tick;

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule